// File: doc/BRIEF.md
# Frame Number Counter and Frame-List Pointer

This block keeps the running frame number of a full/low-speed bus host controller and turns it into the memory address of the frame-list entry to fetch next. An 11-bit counter steps once per frame when an external frame timer pulses `eof_strobe` while the controller is set to run. The counter's value is the frame number carried in the start-of-frame token. Its low ten bits select one of 1024 DWORD entries in a list that starts on a 4 KB boundary. The start of that list is held in a separate base register.

Software reaches both registers through a small register port. `reg_sel` picks the register, `reg_be` gives byte enables, and reads come back combinationally on `reg_rdata`. The frame number may only be loaded when the controller is stopped, and only by a full 16-bit write. A three-state run tracker enforces the stopped condition. Its states and transitions are:
- ST_STOPPED, the state out of reset.
- ST_RUNNING.
- ST_STOPPING.
- T_START: ST_STOPPED to ST_RUNNING when `run_en` is high.
- T_STOP_REQ: ST_RUNNING to ST_STOPPING when `run_en` is low.
- T_HALT_SEEN: ST_STOPPING to ST_STOPPED when `halted` is high and `run_en` is low.
- T_RESUME: ST_STOPPING to ST_RUNNING when `run_en` is high.

In every other case the tracker keeps its state.

Top module: `frame_list_ptr`

## Requirements
- R1: After reset the frame number reads 0 and the run tracker is in ST_STOPPED.
- R2: The frame number increments by one on every clock edge where `eof_strobe` and `run_en` are both high. It does not change on an `eof_strobe` while `run_en` is low.
- R3: The counter is 11 bits wide and steps from 2047 to 0. The list index (bits 9:0) therefore steps from 1023 to 0.
- R4: Reading the frame register (`reg_sel`=0) returns the counter in bits 10:0. All of bits 31:11 read as zero.
- R5: Writing the base register (`reg_sel`=1) updates only address bits 31:12. Each of those bits changes only when its byte lane enable `reg_be[bit/8]` is set. Reads of the base register return bits 11:0 as zero.
- R6: `fetch_addr` equals {base bits 31:12, frame bits 9:0, 2'b00}, taken from the register values of the previous clock cycle.
- R7: A frame-register write is ignored while `run_en` is high.
- R8: A frame-register write is ignored unless both `reg_be[0]` and `reg_be[1]` are set.
- R9: A frame-register write loads bits 10:0 of `reg_wdata` when all of the following hold: the tracker is in ST_STOPPED, `halted` is high, `run_en` is low, and R8 is met.
- R10: The tracker follows T_START, T_STOP_REQ, T_HALT_SEEN and T_RESUME as described above. In ST_STOPPING, and on the cycle where `halted` first rises there, frame writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_strobe | input | 1 | One-cycle end-of-frame pulse from the frame timer |
| run_en | input | 1 | Run/stop control bit, high = run |
| halted | input | 1 | Controller reports it has halted |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = frame number, 1 = list base |
| reg_be | input | 4 | Byte lane enables for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| fetch_addr | output | 32 | DWORD address of the current frame-list entry |

## Verification
The hardest case to reach is the stop handshake. `run_en` has fallen but `halted` has not yet risen, or has only just risen, and a frame write arrives in that gap. The directed stimulus walks the tracker through ST_RUNNING and ST_STOPPING explicitly. It places writes on the ST_STOPPING cycles and on the first halted cycle, then shows that the write only lands one cycle later. The counter wrap needs 2048 frames from reset. The bench instead loads 2046 while stopped and then pulses two frames. The random phase toggles `run_en` and `halted` independently, so every transition is also taken many times with writes landing on each side of it.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_STOPPING = 2'd2
    } run_state_e;

    localparam logic SEL_FRAME = 1'b0;
    localparam logic SEL_BASE  = 1'b1;
endpackage

// File: rtl/fl_run_fsm.sv
module fl_run_fsm
    import fl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic halted,
    output logic load_ok
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (run_en) state_d = ST_RUNNING;              // T_START
            ST_RUNNING:  if (!run_en) state_d = ST_STOPPING;            // T_STOP_REQ
            ST_STOPPING: begin
                if (run_en)      state_d = ST_RUNNING;                  // T_RESUME
                else if (halted) state_d = ST_STOPPED;                  // T_HALT_SEEN
            end
            default:     state_d = ST_STOPPED;
        endcase
    end

    always_comb begin
        load_ok = 1'b0;
        unique case (state_q)
            ST_STOPPED:  load_ok = halted && !run_en;
            ST_RUNNING:  load_ok = 1'b0;
            ST_STOPPING: load_ok = 1'b0;
            default:     load_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fl_frame_ctr.sv
module fl_frame_ctr #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    output logic [FRAME_W-1:0] frame_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     frame_q <= '0;
        else if (load)  frame_q <= load_val;
        else if (step)  frame_q <= frame_q + 1'b1;
    end
endmodule

// File: rtl/fl_base_reg.sv
module fl_base_reg #(
    parameter int ADDR_W   = 32,
    parameter int BASE_LSB = 12,
    localparam int BE_W    = ADDR_W / 8,
    localparam int KEEP_W  = ADDR_W - BASE_LSB
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    input  logic [KEEP_W-1:0] wdata,
    output logic [KEEP_W-1:0] base_q
);
    logic [KEEP_W-1:0] bit_en;
    logic [KEEP_W-1:0] base_d;

    for (genvar b = 0; b < KEEP_W; b++) begin : g_lane
        assign bit_en[b] = be[(b + BASE_LSB) / 8];
    end

    always_comb begin
        base_d = base_q;
        if (wr) base_d = (base_q & ~bit_en) | (wdata & bit_en);
    end

    always_ff @(posedge clk) begin
        base_q <= base_d;
    end
endmodule

// File: rtl/fl_fetch_addr.sv
module fl_fetch_addr #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    localparam int BASE_LSB = IDX_W + 2,
    localparam int KEEP_W  = ADDR_W - BASE_LSB
) (
    input  logic              clk,
    input  logic [KEEP_W-1:0] base_hi,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] fetch_addr
);
    always_ff @(posedge clk) begin
        fetch_addr <= {base_hi, index, 2'b00};
    end
endmodule

// File: rtl/frame_list_ptr.sv
module frame_list_ptr
    import fl_pkg::*;
#(
    parameter int FRAME_W     = 11,
    parameter int IDX_W       = 10,
    parameter int ADDR_W      = 32,
    parameter int FRAME_REG_W = 16,
    localparam int BASE_LSB   = IDX_W + 2,
    localparam int KEEP_W     = ADDR_W - BASE_LSB,
    localparam int BE_W       = ADDR_W / 8,
    localparam int FR_LANES   = FRAME_REG_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eof_strobe,
    input  logic              run_en,
    input  logic              halted,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic               load_ok;
    logic               frame_load;
    logic               frame_step;
    logic [FRAME_W-1:0] frame_q;
    logic [KEEP_W-1:0]  base_q;
    logic               wdata_unused;

    assign wdata_unused = ^reg_wdata[BASE_LSB-1:FRAME_W];

    fl_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .halted  (halted),
        .load_ok (load_ok)
    );

    assign frame_load = reg_wr && (reg_sel == SEL_FRAME) && load_ok
                      && (&reg_be[FR_LANES-1:0]);
    assign frame_step = eof_strobe && run_en;

    fl_frame_ctr #(.FRAME_W(FRAME_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (frame_step),
        .load     (frame_load),
        .load_val (reg_wdata[FRAME_W-1:0]),
        .frame_q  (frame_q)
    );

    fl_base_reg #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_base (
        .clk    (clk),
        .wr     (reg_wr && (reg_sel == SEL_BASE)),
        .be     (reg_be),
        .wdata  (reg_wdata[ADDR_W-1:BASE_LSB]),
        .base_q (base_q)
    );

    fl_fetch_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch (
        .clk        (clk),
        .base_hi    (base_q),
        .index      (frame_q[IDX_W-1:0]),
        .fetch_addr (fetch_addr)
    );

    always_comb begin
        if (reg_sel == SEL_FRAME) reg_rdata = {{(ADDR_W-FRAME_W){1'b0}}, frame_q};
        else                      reg_rdata = {base_q, {BASE_LSB{1'b0}}};
    end
endmodule

// File: rtl/fl_ptr_checker.sv
module fl_ptr_checker #(
    parameter int FRAME_W = 11,
    parameter int IDX_W   = 10,
    parameter int ADDR_W  = 32,
    localparam int BASE_LSB = IDX_W + 2,
    localparam int KEEP_W   = ADDR_W - BASE_LSB,
    localparam int BE_W     = ADDR_W / 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eof_strobe,
    input logic               run_en,
    input logic               reg_wr,
    input logic               reg_sel,
    input logic [BE_W-1:0]    reg_be,
    input logic [ADDR_W-1:0]  reg_rdata,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic [FRAME_W-1:0] frame_q,
    input logic [KEEP_W-1:0]  base_q
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && run_en) |=> (frame_q == FRAME_W'($past(frame_q) + 1'b1)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_strobe && run_en && (&frame_q)) |=> (frame_q == '0));

    p_run_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && run_en && !eof_strobe) |=> $stable(frame_q));

    p_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !(&reg_be[1:0]) && !(eof_strobe && run_en)) |=> $stable(frame_q));

    p_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fetch_addr == {$past(base_q), $past(frame_q[IDX_W-1:0]), 2'b00}));

    p_base_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[BASE_LSB-1:0] == '0));
endmodule

bind frame_list_ptr fl_ptr_checker #(
    .FRAME_W (FRAME_W),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eof_strobe (eof_strobe),
    .run_en     (run_en),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_be     (reg_be),
    .reg_rdata  (reg_rdata),
    .fetch_addr (fetch_addr),
    .frame_q    (frame_q),
    .base_q     (base_q)
);

// File: tb/tb_frame_list_ptr.sv
`timescale 1ns/1ps
module tb_frame_list_ptr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof_strobe = 1'b0;
    logic        run_en = 1'b0;
    logic        halted = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] fetch_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frame_list_ptr dut (
        .clk(clk), .rst_n(rst_n), .eof_strobe(eof_strobe), .run_en(run_en),
        .halted(halted), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr)
    );

    // model state: 0 stopped, 1 running, 2 stopping
    int          m_st = 0;
    logic [10:0] m_frame = '0;
    logic [19:0] m_base = '0;
    bit          base_known = 1'b0;
    logic [31:0] m_fetch = '0;

    function automatic logic [31:0] exp_read(input logic sel);
        return sel ? {m_base, 12'h000} : {21'h0, m_frame};
    endfunction

    function automatic int next_state(input int st, input logic run, input logic hlt);
        case (st)
            0: return run ? 1 : 0;
            1: return run ? 1 : 2;
            default: return run ? 1 : (hlt ? 0 : 2);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic eof, input logic run, input logic hlt,
                        input logic wr, input logic sel, input logic [3:0] be,
                        input logic [31:0] wd, input string tag);
        logic accept;
        @(negedge clk);
        eof_strobe = eof; run_en = run; halted = hlt;
        reg_wr = wr; reg_sel = sel; reg_be = be; reg_wdata = wd;
        m_fetch = {m_base, m_frame[9:0], 2'b00};
        accept = (m_st == 0) && hlt && !run && wr && !sel && (&be[1:0]);
        if (accept)          m_frame = wd[10:0];
        else if (eof && run) m_frame = m_frame + 11'd1;
        if (wr && sel) begin
            for (int b = 12; b < 32; b++) if (be[b/8]) m_base[b-12] = wd[b];
        end
        m_st = next_state(m_st, run, hlt);
        @(posedge clk);
        #1;
        check({tag, " read"}, reg_rdata, exp_read(sel));
        if (base_known) check("R6 fetch_addr", fetch_addr, m_fetch);
        if (wr && sel && (&be[3:1])) base_known = 1'b1;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset frame", reg_rdata, 32'h0);

        // R5 base writes
        step(0, 0, 1, 1, 1, 4'hF, 32'hABCDE123, "R5 full base write");
        step(0, 0, 1, 1, 1, 4'b0100, 32'h00550000, "R5 lane2 base write");
        step(0, 0, 1, 1, 1, 4'b0001, 32'hFFFFFFFF, "R5 lane0 only");
        step(0, 0, 1, 0, 1, 4'h0, 32'h0, "R5 base readback");
        // R9 / R4 frame write while stopped
        step(0, 0, 1, 1, 0, 4'b0011, 32'hFFFFFFFF, "R4 reserved zero");
        step(0, 0, 1, 1, 0, 4'b0011, 32'h000007FE, "R9 load 2046");
        step(0, 0, 1, 1, 0, 4'b0001, 32'h00000005, "R8 partial be");
        step(0, 0, 1, 1, 0, 4'b0010, 32'h00000005, "R8 partial be high");
        // R10 T_START, R7 write while running
        step(0, 1, 0, 1, 0, 4'b0011, 32'h00000123, "R7 write while run");
        step(0, 1, 0, 1, 0, 4'b1111, 32'h00000321, "R7 write in RUNNING");
        // R2/R3 counting and wrap
        step(1, 1, 0, 0, 0, 4'h0, 32'h0, "R2 increment");
        step(1, 1, 0, 0, 0, 4'h0, 32'h0, "R3 wrap to zero");
        step(0, 1, 0, 0, 0, 4'h0, 32'h0, "R6 idle");
        step(1, 1, 0, 0, 0, 4'h0, 32'h0, "R2 increment after wrap");
        check("R3 value one", reg_rdata, 32'h1);
        // R10 stopping window
        step(1, 0, 0, 1, 0, 4'b0011, 32'h00000077, "R2 eof ignored run low; R10 STOPPING");
        step(0, 0, 0, 1, 0, 4'b0011, 32'h00000077, "R10 write in STOPPING");
        step(0, 0, 1, 1, 0, 4'b0011, 32'h00000077, "R10 first halted cycle");
        step(0, 0, 1, 1, 0, 4'b0011, 32'h00000077, "R9 write after T_HALT_SEEN");
        check("R9 loaded value", reg_rdata, 32'h77);
        // T_RESUME path
        step(0, 1, 0, 0, 0, 4'h0, 32'h0, "R10 start");
        step(0, 0, 0, 0, 0, 4'h0, 32'h0, "R10 stop request");
        step(0, 1, 0, 0, 0, 4'h0, 32'h0, "R10 resume");
        step(0, 1, 1, 1, 0, 4'b0011, 32'h0, "R10 resumed blocks write");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic run_r, hlt_r, wr_r, sel_r, eof_r;
            logic [3:0] be_r;
            logic [31:0] wd_r;
            run_r = ($urandom % 4) != 0 ? run_en : ~run_en;
            hlt_r = ($urandom % 3) != 0 ? halted : ~halted;
            eof_r = ($urandom % 3) == 0;
            wr_r  = ($urandom % 3) == 0;
            sel_r = ($urandom % 4) == 0;
            be_r  = 4'($urandom);
            wd_r  = $urandom;
            step(eof_r, run_r, hlt_r, wr_r, sel_r, be_r, wd_r, "R2 R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule